// File: doc/BRIEF.md
# Tick Timer with Free-Running Timestamp

This block keeps two counters for an operating system's time base. A timestamp counter counts every clock cycle. Software reads it to measure the time that passed between timer ticks, and it may overwrite it, for example with zero, to restart the count. A down-counting tick timer raises a pending flag each time it expires, and it holds an interrupt line high while that flag is set. The timer either reloads by itself (periodic) or stops after one expiry (one-shot).

The timer's control word holds the reload value and the mode in a single register. The two lowest bits are control bits: bit 0 enables counting and bit 1 selects one-shot mode. The reload value is that same word with both of those bits forced to zero, so every period is a multiple of four plus one cycle. Software reaches all state over a plain single-cycle register port. A write takes effect at the clock edge on which `reg_wr` is high. A read is combinational from `reg_sel`. There is no handshake, because each access completes in one cycle.

Register map (`reg_sel`): 0 = timestamp, 1 = control word, 2 = status (bit 0 = pending, all other bits read zero), 3 = current down-count (read only).

Top module: `os_tick_timer`

## Requirements
- R1: After reset the timestamp, the control word, the down-count and the pending flag are all zero, and `tick_irq` is low.
- R2: The timestamp rises by one on every clock edge with no write to select 0, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to select 0 loads the timestamp with the write data at that edge, and counting continues from that value on the following edges.
- R4: A write to select 1 stores the whole word as the control word (readable at select 1) and loads the down-count at once with the word's bits 1:0 forced to zero.
- R5: While control bit 0 (enable) is zero and select 1 is not written, the down-count holds its value.
- R6: When enabled and the down-count is zero at a clock edge, the timer expires: the pending flag is set and, with bit 1 clear, the down-count reloads from the reload value. The period is therefore reload + 1 cycles.
- R7: On expiry with bit 1 (one-shot) set, the timer clears control bit 0 instead of reloading, the down-count stays at zero, and the pending flag is set.
- R8: Writing select 2 with bit 0 set clears the pending flag. Writing it with bit 0 clear has no effect. An expiry in the same cycle wins over the clear.
- R9: `tick_irq` is high exactly while the pending flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| tick_irq | output | 1 | Tick interrupt, high while pending |

## Verification
Directed runs use a reload of 8 in periodic mode, the same reload in one-shot mode, and a disabled timer. These separate reload-on-expiry from stop-on-expiry and from holding the count. A timestamp write of 0xFFFFFFFE followed by free counting exposes a wrong wrap. Repeated clear writes during short periods make a clear coincide with an expiry, which shows whether set or clear has priority. Random mixes of writes to every register, with small reload values, catch a reload-register write landing on the very cycle the timer expires.

// File: rtl/ostt_pkg.sv
package ostt_pkg;
  typedef enum logic [1:0] {
    SEL_STAMP  = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_COUNT  = 2'd3
  } ostt_sel_e;

  localparam int CTRL_BITS = 2;
  localparam int EN_BIT    = 0;
  localparam int ONE_BIT   = 1;
endpackage

// File: rtl/ostt_stamp.sv
module ostt_stamp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] stamp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stamp <= '0;
    else if (load) stamp <= load_val;
    else           stamp <= stamp + 1'b1;
  end

  p_stamp_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> stamp == $past(stamp) + 1'b1);
  p_stamp_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> stamp == $past(load_val));
endmodule

// File: rtl/ostt_tick.sv
module ostt_tick
  import ostt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr,
  input  logic [W-1:0] ctrl_wdata,
  input  logic         ack_wr,
  input  logic         ack_bit,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] count_q,
  output logic         pend_q
);
  localparam logic [W-1:0] CTRL_MASK = W'((1 << CTRL_BITS) - 1);

  logic [W-1:0] reload_val;
  logic         expire;

  assign reload_val = ctrl_q & ~CTRL_MASK;
  assign expire     = ctrl_q[EN_BIT] && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      count_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q  <= ctrl_wdata;
      count_q <= ctrl_wdata & ~CTRL_MASK;
    end else if (expire) begin
      if (ctrl_q[ONE_BIT]) ctrl_q[EN_BIT] <= 1'b0;
      else                 count_q <= reload_val;
    end else if (ctrl_q[EN_BIT]) begin
      count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (expire)             pend_q <= 1'b1;
    else if (ack_wr && ack_bit)  pend_q <= 1'b0;
  end

  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[EN_BIT] && !ctrl_wr) |=> $stable(count_q));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_wr && !ctrl_q[ONE_BIT]) |=> count_q == $past(reload_val));
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q);
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_wr && ctrl_q[ONE_BIT]) |=> (!ctrl_q[EN_BIT] && count_q == '0));
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ack_bit && !expire) |=> !pend_q);
endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer
  import ostt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_irq
);
  ostt_sel_e         sel;
  logic [DATA_W-1:0] stamp;
  logic [DATA_W-1:0] ctrl;
  logic [DATA_W-1:0] count;
  logic              pend;

  assign sel = ostt_sel_e'(reg_sel);

  ostt_stamp #(.W(DATA_W)) u_stamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reg_wr && sel == SEL_STAMP),
    .load_val (reg_wdata),
    .stamp    (stamp)
  );

  ostt_tick #(.W(DATA_W)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (reg_wr && sel == SEL_CTRL),
    .ctrl_wdata (reg_wdata),
    .ack_wr     (reg_wr && sel == SEL_STATUS),
    .ack_bit    (reg_wdata[0]),
    .ctrl_q     (ctrl),
    .count_q    (count),
    .pend_q     (pend)
  );

  always_comb begin
    unique case (sel)
      SEL_STAMP:  reg_rdata = stamp;
      SEL_CTRL:   reg_rdata = ctrl;
      SEL_STATUS: reg_rdata = {{(DATA_W-1){1'b0}}, pend};
      default:    reg_rdata = count;
    endcase
  end

  assign tick_irq = pend;

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_irq) |-> $past(ctrl[EN_BIT]) && $past(count) == '0);
endmodule

// File: tb/test_os_tick_timer.sv
module test_os_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_irq;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_ts, m_ctrl, m_cnt;
  logic        m_pend;

  always #4 clk = ~clk;

  os_tick_timer i_os_tick_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_irq(tick_irq)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] s);
    case (s)
      2'd0: return m_ts;
      2'd1: return m_ctrl;
      2'd2: return {31'b0, m_pend};
      default: return m_cnt;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic wr, input logic [1:0] s, input logic [31:0] d);
    logic expire;
    expire = m_ctrl[0] && (m_cnt == 0);
    m_ts = (wr && s == 2'd0) ? d : m_ts + 1;
    if (expire) m_pend = 1'b1;
    else if (wr && s == 2'd2 && d[0]) m_pend = 1'b0;
    if (wr && s == 2'd1) begin
      m_ctrl = d;
      m_cnt  = d & ~32'd3;
    end else if (expire) begin
      if (m_ctrl[1]) m_ctrl[0] = 1'b0;
      else           m_cnt = m_ctrl & ~32'd3;
    end else if (m_ctrl[0]) begin
      m_cnt = m_cnt - 1;
    end
  endtask

  // Called at a negedge: drive, check current state, advance one cycle.
  task automatic step(input logic wr, input logic [1:0] s, input logic [31:0] d, input string req);
    reg_wr = wr; reg_sel = s; reg_wdata = d;
    #1;
    check(req, reg_rdata, exp_read(s));
    check("R9", {31'b0, tick_irq}, {31'b0, m_pend});
    model_step(wr, s, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_ts = 0; m_ctrl = 0; m_cnt = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every register
    for (int i = 0; i < 4; i++) step(1'b0, 2'(i), 32'd0, "R1");
    // R3 load then R2 wrap
    step(1'b1, 2'd0, 32'hFFFF_FFFE, "R3");
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, 32'd0, "R2");
    // R4 load while disabled, R5 hold
    step(1'b1, 2'd1, 32'd22, "R4");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd3, 32'd0, "R5");
    // R6 periodic reload 8
    step(1'b1, 2'd1, 32'd9, "R4");
    for (int i = 0; i < 20; i++) step(1'b0, 2'(2 + (i % 2)), 32'd0, "R6");
    // R8 write zero no effect, then clear
    step(1'b1, 2'd2, 32'd0, "R8");
    step(1'b1, 2'd2, 32'd1, "R8");
    step(1'b0, 2'd2, 32'd0, "R8");
    // R7 one-shot reload 8
    step(1'b1, 2'd2, 32'd1, "R8");
    step(1'b1, 2'd1, 32'd11, "R4");
    for (int i = 0; i < 14; i++) step(1'b0, 2'(1 + 2 * (i % 2)), 32'd0, "R7");
    // R8 clear colliding with short-period expiries
    step(1'b1, 2'd1, 32'd5, "R4");
    for (int i = 0; i < 15; i++) step(1'b1, 2'd2, 32'd1, "R8");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0]  s;
      logic        w;
      logic [31:0] d;
      s = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 9) == 0);
      d = (s == 2'd1) ? 32'($urandom_range(0, 40)) : $urandom;
      case (s)
        2'd0: step(w, s, d, w ? "R3" : "R2");
        2'd1: step(w, s, d, "R4");
        2'd2: step(w, s, d, "R8");
        default: step(w, s, d, "R6");
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule